// File: doc/BRIEF.md
# Load/Store Address and Byte-Lane Unit

This block sits between a decoded memory instruction and a byte-addressable, little-endian data memory. It receives the instruction's opcode, the register values for base, index and target, and the 12-bit offset field. In the same cycle it forms the memory address and decides whether the access is a read or a write. It also produces per-byte write enables and write data with the register's low bytes copied onto the right lanes.

The memory is synchronous and returns read data one cycle after a read request. The unit keeps the byte lane and the access size of each accepted load for that one cycle. It then extracts the addressed byte, half-word or word from the returned memory word and zero-extends it for register writeback, with a one-cycle valid pulse. An access whose address does not match its size is refused at the memory port, and an error pulse is raised instead.

Top module: `lsu_lane_unit`

## Requirements
- R1: In offset mode (odd opcodes 17, 19, 21, 23, 25, 27), the address is base plus the 12-bit offset, zero-extended and taken modulo 2^32. An offset with bit 11 set therefore adds 2048 or more and never subtracts.
- R2: In index mode (even opcodes 18, 20, 22, 24, 26, 28), the address is base plus index, modulo 2^32.
- R3: Opcodes 17/18, 19/20 and 21/22 are byte, half-word and word loads, and 23/24, 25/26 and 27/28 are byte, half-word and word stores. Any other opcode, a request with req_valid_i low, or a request while rst is high causes no access: mem_we_o, mem_re_o and mem_be_o are all zero, and no valid or error pulse follows.
- R4: For an aligned access, mem_be_o bit k enables the byte at word address + k. A byte access sets one bit, selected by address[1:0]. A half-word access sets 4'b0011 or 4'b1100. A word access sets 4'b1111. mem_we_o (store) or mem_re_o (load) is high combinationally in the request cycle.
- R5: A store changes only the enabled bytes. A byte store writes target[7:0], and a half-word store writes target[15:0].
- R6: A load raises ld_valid_o for exactly the one cycle after the request edge. In that cycle ld_data_o holds the addressed data, zero-extended to 32 bits.
- R7: Memory is little-endian. The byte at word address + 0 is bits 7:0 of the memory word, and the byte at + 3 is bits 31:24.
- R8: A half-word access with address[0] = 1, or a word access with address[1:0] ≠ 0, is misaligned. It drives mem_we_o, mem_re_o and mem_be_o to zero, raises err_o for the one cycle after the request edge, and does not raise ld_valid_o.
- R9: While rst is high and in the first cycle after reset, ld_valid_o and err_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Instruction present this cycle |
| opcode_i | input | 6 | Decoded opcode |
| base_i | input | 32 | Base register value |
| index_i | input | 32 | Index register value |
| target_i | input | 32 | Target register value (store source) |
| offset_i | input | 12 | Unsigned offset field |
| mem_addr_o | output | 32 | Byte address to memory |
| mem_be_o | output | 4 | Byte-lane enables |
| mem_we_o | output | 1 | Write strobe |
| mem_re_o | output | 1 | Read strobe |
| mem_wdata_o | output | 32 | Lane-replicated write data |
| mem_rdata_i | input | 32 | Word returned by memory one cycle after mem_re_o |
| ld_data_o | output | 32 | Zero-extended load result |
| ld_valid_o | output | 1 | Load result valid pulse |
| err_o | output | 1 | Misaligned-access pulse |

## Verification
The bench sends offsets with bit 11 set from a base near the top of the address space. A design that sign-extends the offset would land 4 KiB too low and read the wrong byte. Index-mode sums that wrap past 2^32 catch an adder that is too narrow. Byte and half-word stores are read back as whole words, so a design that writes disabled lanes, or places a lane on the wrong byte, shows up as corrupted neighbouring bytes. Misaligned loads and stores are followed by reads of the same word, and opcodes outside the memory range and requests made during reset are checked for silence at the memory port. Together these expose a design that writes anyway, or that reports a valid result when it should raise only the error pulse.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

  // Access width; the numeric value is log2 of the byte count.
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_e;

  typedef struct packed {
    logic      hit;        // opcode is a load or store
    logic      is_store;
    logic      use_index;  // index mode instead of offset mode
    acc_size_e size;
  } mem_op_t;

  // The memory opcodes form one contiguous run: loads first, then stores,
  // each group ordered byte/half/word with offset/index pairs.
  localparam int unsigned MEM_OPC_FIRST = 17;
  localparam int unsigned MEM_OPC_COUNT = 12;
  localparam int unsigned STORE_GROUP   = 6;

endpackage

// File: rtl/lsu_decode.sv
module lsu_decode
  import lsu_pkg::*;
#(
  parameter int OPC_W = 6
) (
  input  logic [OPC_W-1:0] opcode,
  output mem_op_t          dec
);

  logic [31:0] rel;
  logic [2:0]  grp;

  always_comb begin
    rel           = {{(32-OPC_W){1'b0}}, opcode} - 32'(MEM_OPC_FIRST);
    dec.hit       = (opcode >= OPC_W'(MEM_OPC_FIRST)) && (rel < 32'(MEM_OPC_COUNT));
    dec.is_store  = (rel >= 32'(STORE_GROUP));
    grp           = dec.is_store ? (rel[2:0] - 3'(STORE_GROUP)) : rel[2:0];
    dec.size      = acc_size_e'(grp[2:1]);
    dec.use_index = grp[0];
  end

endmodule

// File: rtl/lsu_agen.sv
module lsu_agen
  import lsu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFS_W  = 12,
  parameter int LANES  = 4
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] index,
  input  logic [OFS_W-1:0]  offset,
  input  logic              use_index,
  input  acc_size_e         size,
  output logic [ADDR_W-1:0] addr,
  output logic              misaligned,
  output logic [LANES-1:0]  be
);

  localparam int LSB_W = $clog2(LANES);

  logic [ADDR_W-1:0] addend;
  logic [LSB_W-1:0]  low_mask;
  logic [LANES-1:0]  foot;

  always_comb begin
    // Offset is unsigned: zero-extend before the add.
    addend     = use_index ? index : {{(ADDR_W-OFS_W){1'b0}}, offset};
    addr       = base + addend;
    low_mask   = LSB_W'((1 << int'(size)) - 1);
    misaligned = |(addr[LSB_W-1:0] & low_mask);
    foot       = LANES'((1 << (1 << int'(size))) - 1);
    be         = misaligned ? '0 : (foot << addr[LSB_W-1:0]);
  end

endmodule

// File: rtl/lsu_store_lanes.sv
module lsu_store_lanes
  import lsu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] target,
  input  acc_size_e         size,
  output logic [DATA_W-1:0] wdata
);

  localparam int LANES = DATA_W / 8;

  // Each lane carries the source byte it would hold for an aligned access,
  // so enables alone pick which bytes land in memory.
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_comb begin
      unique case (size)
        SZ_BYTE: wdata[8*i +: 8] = target[7:0];
        SZ_HALF: wdata[8*i +: 8] = target[8*(i % 2) +: 8];
        default: wdata[8*i +: 8] = target[8*(i % 4) +: 8];
      endcase
    end
  end

endmodule

// File: rtl/lsu_load_align.sv
module lsu_load_align
  import lsu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue,
  input  logic              fault,
  input  logic [$clog2(DATA_W/8)-1:0] lane,
  input  acc_size_e         size,
  input  logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] ld_data,
  output logic              ld_valid,
  output logic              err
);

  localparam int LSB_W = $clog2(DATA_W / 8);

  logic [LSB_W-1:0]  lane_q;
  acc_size_e         size_q;
  logic [DATA_W-1:0] shifted;

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_valid <= 1'b0;
      err      <= 1'b0;
      lane_q   <= '0;
      size_q   <= SZ_WORD;
    end else begin
      ld_valid <= issue;
      err      <= fault;
      if (issue) begin
        lane_q <= lane;
        size_q <= size;
      end
    end
  end

  always_comb begin
    shifted = rdata >> (8 * int'(lane_q));
    unique case (size_q)
      SZ_BYTE: ld_data = {{(DATA_W-8){1'b0}}, shifted[7:0]};
      SZ_HALF: ld_data = {{(DATA_W-16){1'b0}}, shifted[15:0]};
      default: ld_data = shifted;
    endcase
  end

  // R6
  valid_follows_read_chk: assert property (@(posedge clk) disable iff (rst)
    ld_valid |-> $past(issue));

  // R8
  err_excludes_valid_chk: assert property (@(posedge clk) disable iff (rst)
    err |-> !ld_valid);

endmodule

// File: rtl/lsu_lane_unit.sv
module lsu_lane_unit
  import lsu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int OFS_W  = 12,
  parameter int OPC_W  = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid_i,
  input  logic [OPC_W-1:0]    opcode_i,
  input  logic [ADDR_W-1:0]   base_i,
  input  logic [ADDR_W-1:0]   index_i,
  input  logic [DATA_W-1:0]   target_i,
  input  logic [OFS_W-1:0]    offset_i,
  output logic [ADDR_W-1:0]   mem_addr_o,
  output logic [DATA_W/8-1:0] mem_be_o,
  output logic                mem_we_o,
  output logic                mem_re_o,
  output logic [DATA_W-1:0]   mem_wdata_o,
  input  logic [DATA_W-1:0]   mem_rdata_i,
  output logic [DATA_W-1:0]   ld_data_o,
  output logic                ld_valid_o,
  output logic                err_o
);

  localparam int LANES = DATA_W / 8;
  localparam int LSB_W = $clog2(LANES);

  mem_op_t          dec;
  logic             mis;
  logic [LANES-1:0] be_raw;
  logic             active;
  logic             fault;

  lsu_decode #(.OPC_W(OPC_W)) u_decode (
    .opcode (opcode_i),
    .dec    (dec)
  );

  lsu_agen #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .LANES(LANES)) u_agen (
    .base       (base_i),
    .index      (index_i),
    .offset     (offset_i),
    .use_index  (dec.use_index),
    .size       (dec.size),
    .addr       (mem_addr_o),
    .misaligned (mis),
    .be         (be_raw)
  );

  lsu_store_lanes #(.DATA_W(DATA_W)) u_store (
    .target (target_i),
    .size   (dec.size),
    .wdata  (mem_wdata_o)
  );

  always_comb begin
    active   = req_valid_i && !rst && dec.hit && !mis;
    fault    = req_valid_i && !rst && dec.hit && mis;
    mem_we_o = active && dec.is_store;
    mem_re_o = active && !dec.is_store;
    mem_be_o = active ? be_raw : '0;
  end

  lsu_load_align #(.DATA_W(DATA_W)) u_load (
    .clk      (clk),
    .rst      (rst),
    .issue    (mem_re_o),
    .fault    (fault),
    .lane     (mem_addr_o[LSB_W-1:0]),
    .size     (dec.size),
    .rdata    (mem_rdata_i),
    .ld_data  (ld_data_o),
    .ld_valid (ld_valid_o),
    .err      (err_o)
  );

  // R3
  one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    !(mem_we_o && mem_re_o));

  // R4
  store_lane_count_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we_o |-> ($countones(mem_be_o) == 1 || $countones(mem_be_o) == 2 ||
                  $countones(mem_be_o) == 4));

  // R8
  strobe_has_lanes_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_we_o || mem_re_o) |-> (mem_be_o != '0));

  // R8
  error_after_fault_chk: assert property (@(posedge clk) disable iff (rst)
    err_o |-> !$past(mem_we_o || mem_re_o));

endmodule

// File: tb/lsu_lane_unit_tb.sv
module lsu_lane_unit_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int MEM_WORDS  = 256;
  localparam int MEM_AW     = $clog2(MEM_WORDS);

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [5:0]  opcode = '0;
  logic [31:0] base = '0, index = '0, target = '0;
  logic [11:0] offset = '0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, ld_data;
  logic [3:0]  mem_be;
  logic        mem_we, mem_re, ld_valid, err;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lsu_lane_unit dut_i (
    .clk(clk), .rst(rst), .req_valid_i(req_valid), .opcode_i(opcode),
    .base_i(base), .index_i(index), .target_i(target), .offset_i(offset),
    .mem_addr_o(mem_addr), .mem_be_o(mem_be), .mem_we_o(mem_we),
    .mem_re_o(mem_re), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .ld_data_o(ld_data), .ld_valid_o(ld_valid), .err_o(err)
  );

  // Synchronous byte-enabled memory model
  logic [31:0] mem [MEM_WORDS];
  initial for (int i = 0; i < MEM_WORDS; i++) mem[i] = '0;

  always_ff @(posedge clk) begin
    if (mem_we)
      for (int b = 0; b < 4; b++)
        if (mem_be[b]) mem[mem_addr[MEM_AW+1:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
    if (mem_re) mem_rdata <= mem[mem_addr[MEM_AW+1:2]];
  end

  typedef struct packed {
    logic [5:0]  op;
    logic [31:0] base;
    logic [31:0] idx;
    logic [31:0] tgt;
    logic [11:0] ofs;
    logic        chk_addr;
    logic [31:0] eaddr;
    logic [3:0]  ebe;
    logic        ewe;
    logic        ere;
    logic        eerr;
    logic [31:0] eld;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VEC [NV] = '{
    '{6'd27, 32'h100, 32'h0, 32'hA1B2C3D4, 12'h004, 1'b1, 32'h104, 4'hF, 1'b1, 1'b0, 1'b0, 32'h0},
    '{6'd24, 32'h100, 32'h9, 32'h55667788, 12'h000, 1'b1, 32'h109, 4'h2, 1'b1, 1'b0, 1'b0, 32'h0},
    '{6'd25, 32'h10C, 32'h0, 32'h1234BEEF, 12'h002, 1'b1, 32'h10E, 4'hC, 1'b1, 1'b0, 1'b0, 32'h0},
    '{6'd22, 32'h100, 32'h4, 32'h0, 12'h000, 1'b1, 32'h104, 4'hF, 1'b0, 1'b1, 1'b0, 32'hA1B2C3D4},
    '{6'd17, 32'h0, 32'h0, 32'h0, 12'h105, 1'b1, 32'h105, 4'h2, 1'b0, 1'b1, 1'b0, 32'h000000C3},
    '{6'd18, 32'h108, 32'h1, 32'h0, 12'h000, 1'b1, 32'h109, 4'h2, 1'b0, 1'b1, 1'b0, 32'h00000088},
    '{6'd19, 32'h100, 32'h0, 32'h0, 12'h00E, 1'b1, 32'h10E, 4'hC, 1'b0, 1'b1, 1'b0, 32'h0000BEEF},
    '{6'd20, 32'h104, 32'h2, 32'h0, 12'h000, 1'b1, 32'h106, 4'hC, 1'b0, 1'b1, 1'b0, 32'h0000A1B2},
    '{6'd21, 32'h0, 32'h0, 32'h0, 12'h108, 1'b1, 32'h108, 4'hF, 1'b0, 1'b1, 1'b0, 32'h00008800},
    '{6'd17, 32'hFFFFF907, 32'h0, 32'h0, 12'h800, 1'b1, 32'h107, 4'h8, 1'b0, 1'b1, 1'b0, 32'h000000A1},
    '{6'd20, 32'hFFFFFFFE, 32'h110, 32'h0, 12'h000, 1'b1, 32'h10E, 4'hC, 1'b0, 1'b1, 1'b0, 32'h0000BEEF},
    '{6'd26, 32'h100, 32'h1, 32'h0000FFFF, 12'h000, 1'b1, 32'h101, 4'h0, 1'b0, 1'b0, 1'b1, 32'h0},
    '{6'd21, 32'h100, 32'h0, 32'h0, 12'h002, 1'b1, 32'h102, 4'h0, 1'b0, 1'b0, 1'b1, 32'h0},
    '{6'd19, 32'h101, 32'h0, 32'h0, 12'h000, 1'b1, 32'h101, 4'h0, 1'b0, 1'b0, 1'b1, 32'h0},
    '{6'd11, 32'h100, 32'h4, 32'hFFFFFFFF, 12'h000, 1'b0, 32'h0, 4'h0, 1'b0, 1'b0, 1'b0, 32'h0},
    '{6'd29, 32'h100, 32'h4, 32'hFFFFFFFF, 12'h000, 1'b0, 32'h0, 4'h0, 1'b0, 1'b0, 1'b0, 32'h0},
    '{6'd28, 32'h200, 32'h10, 32'h0BADF00D, 12'h000, 1'b1, 32'h210, 4'hF, 1'b1, 1'b0, 1'b0, 32'h0},
    '{6'd23, 32'h210, 32'h0, 32'h000000EE, 12'h003, 1'b1, 32'h213, 4'h8, 1'b1, 1'b0, 1'b0, 32'h0},
    '{6'd22, 32'h210, 32'h0, 32'h0, 12'h000, 1'b1, 32'h210, 4'hF, 1'b0, 1'b1, 1'b0, 32'hEEADF00D},
    '{6'd21, 32'h100, 32'h0, 32'h0, 12'h000, 1'b1, 32'h100, 4'hF, 1'b0, 1'b1, 1'b0, 32'h00000000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [5:0] op, input logic [31:0] b,
                       input logic [31:0] ix, input logic [31:0] t, input logic [11:0] o);
    req_valid = v; opcode = op; base = b; index = ix; target = t; offset = o;
  endtask

  initial begin
    // R9: requests during reset are dropped, outputs stay quiet
    @(negedge clk);
    drive(1'b1, 6'd27, 32'h300, 32'h0, 32'hDEADBEEF, 12'h000);
    #1;
    chk("R9 no write in reset", {31'b0, mem_we}, 32'h0);
    @(posedge clk); #1;
    chk("R9 ld_valid in reset", {31'b0, ld_valid}, 32'h0);
    chk("R9 err in reset", {31'b0, err}, 32'h0);
    @(negedge clk);
    drive(1'b0, 6'd0, 32'h0, 32'h0, 32'h0, 12'h0);
    rst = 1'b0;
    @(posedge clk); #1;
    chk("R9 ld_valid after reset", {31'b0, ld_valid}, 32'h0);
    chk("R9 err after reset", {31'b0, err}, 32'h0);

    // Vector table: R1 R2 R3 R4 R5 R6 R7 R8
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      drive(1'b1, VEC[v].op, VEC[v].base, VEC[v].idx, VEC[v].tgt, VEC[v].ofs);
      #1;
      if (VEC[v].chk_addr) chk($sformatf("R1/R2 addr v%0d", v), mem_addr, VEC[v].eaddr);
      chk($sformatf("R4/R8 be v%0d", v), {28'b0, mem_be}, {28'b0, VEC[v].ebe});
      chk($sformatf("R3 we v%0d", v), {31'b0, mem_we}, {31'b0, VEC[v].ewe});
      chk($sformatf("R3 re v%0d", v), {31'b0, mem_re}, {31'b0, VEC[v].ere});
      @(posedge clk); #1;
      chk($sformatf("R6 valid v%0d", v), {31'b0, ld_valid}, {31'b0, VEC[v].ere});
      chk($sformatf("R8 err v%0d", v), {31'b0, err}, {31'b0, VEC[v].eerr});
      if (VEC[v].ere) chk($sformatf("R5/R6/R7 data v%0d", v), ld_data, VEC[v].eld);
    end

    // R3: store opcode with req_valid low is ignored
    @(negedge clk);
    drive(1'b0, 6'd27, 32'h300, 32'h0, 32'hCAFEF00D, 12'h000);
    #1;
    chk("R3 idle no write", {31'b0, mem_we}, 32'h0);
    @(posedge clk); #1;
    chk("R3 idle no valid", {31'b0, ld_valid}, 32'h0);

    // R9/R3: word at 0x300 untouched by dropped stores
    @(negedge clk);
    drive(1'b1, 6'd21, 32'h300, 32'h0, 32'h0, 12'h000);
    @(posedge clk); #1;
    chk("R9 dropped store left memory", ld_data, 32'h0);
    chk("R6 valid pulse", {31'b0, ld_valid}, 32'h1);
    @(negedge clk);
    drive(1'b0, 6'd0, 32'h0, 32'h0, 32'h0, 12'h0);
    @(posedge clk); #1;
    chk("R6 valid one cycle", {31'b0, ld_valid}, 32'h0);
    chk("R8 err one cycle", {31'b0, err}, 32'h0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule